// File: doc/BRIEF.md
# Frame Interrupt Pulse Generator

This block produces the active-low maskable interrupt pulse that a video controller sends to the CPU once per frame. A single-cycle frame strobe from the video timing logic starts a pulse. Its length is counted in CPU clock cycles and taken from a run-time programmable length register. The pulse length can be stretched or shortened to make up for delays that other logic adds on the interrupt line, such as level shifters on an expansion bus.

A mode input chooses between two timings. The baseline mode pulls the line low in the cycle after the strobe. The late mode holds the line high for a fixed number of extra cycles first (two by default), then pulls it low for the programmed length. The late mode matches the slower falling edge that a capacitively loaded interrupt line shows on later machines. A busy flag covers the whole sequence. A strobe that arrives while the block is busy has no effect.

Top module: `fip_frame_int`

## Requirements
- R1: Out of reset, int_n_o is 1, busy_o is 0, and the length register holds 32.
- R2: In baseline mode (mode_i = 0), a strobe accepted at clock edge k drives int_n_o to 0 after edges k through k+N-1, where N is the length register value. int_n_o returns to 1 after edge k+N.
- R3: In late mode (mode_i = 1), a strobe accepted at edge k keeps int_n_o at 1 after edges k and k+1. It then drives int_n_o to 0 after edges k+2 through k+N+1, and returns it to 1 after edge k+N+2.
- R4: busy_o is 1 from the edge that accepts a strobe until the edge at which int_n_o returns to 1. At that edge busy_o falls.
- R5: A frame strobe is ignored while busy_o is 1. This holds during the onset delay, during the pulse, and at the edge that ends the pulse. A strobe is accepted again at the first edge where busy_o was 0.
- R6: A strobe that arrives while the length register holds 0 starts nothing: busy_o stays 0 and int_n_o stays 1.
- R7: Asserting len_we_i at an edge loads len_wdata_i into the length register. The new value applies to strobes accepted at later edges. A pulse already in progress keeps the length it started with.
- R8: mode_i is sampled only at the edge that accepts a strobe. Changing it during a sequence does not change the timing of that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_stb_i | input | 1 | Per-frame trigger strobe |
| mode_i | input | 1 | 0 = baseline onset, 1 = late onset |
| len_we_i | input | 1 | Length register write enable |
| len_wdata_i | input | 6 | New pulse length in cycles |
| int_n_o | output | 1 | Interrupt line, active low |
| busy_o | output | 1 | Sequence in progress |

## Verification
The hardest case to reach from the ports is a strobe that lands exactly on the edge where the pulse ends. At that edge the sequencer is still busy, but in the next cycle it is idle. The bench counts cycles from a known strobe so that a second strobe falls on edge k+N, then fires a third strobe at edge k+N+1. The expected trace shows busy_o falling for one cycle and a new pulse starting after it. The bench also holds the strobe high across the whole late-mode onset window, and rewrites the length and flips the mode while a pulse is in progress.

// File: rtl/fip_pkg.sv
package fip_pkg;
  typedef enum logic {
    MODE_BASE = 1'b0,
    MODE_LATE = 1'b1
  } fip_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ONSET = 2'd1,
    ST_PULSE = 2'd2
  } fip_state_e;
endpackage

// File: rtl/fip_down_cnt.sv
module fip_down_cnt #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (dec_i && (cnt_q != '0))   cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fip_len_reg.sv
module fip_len_reg #(
  parameter int LEN_W   = 6,
  parameter int LEN_RST = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LEN_W-1:0] wdata_i,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   len_q <= LEN_W'(LEN_RST);
    else if (we_i) len_q <= wdata_i;
  end

  assign len_o = len_q;
endmodule

// File: rtl/fip_seq.sv
module fip_seq
  import fip_pkg::*;
#(
  parameter int LEN_W     = 6,
  parameter int ONSET_DLY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_stb_i,
  input  logic             mode_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             int_n_o,
  output logic             busy_o
);
  localparam int DLY_W = (ONSET_DLY > 1) ? $clog2(ONSET_DLY) : 1;

  fip_state_e       st_q, st_d;
  logic             accept;
  logic             pcnt_zero;
  logic             dly_zero;
  logic [LEN_W-1:0] pcnt;

  assign accept = frame_stb_i && (st_q == ST_IDLE) && (len_i != '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept)
                  st_d = ((fip_mode_e'(mode_i) == MODE_LATE) && (ONSET_DLY > 0)) ? ST_ONSET : ST_PULSE;
      ST_ONSET: if (dly_zero)  st_d = ST_PULSE;
      ST_PULSE: if (pcnt_zero) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // length is captured at accept; later register writes do not reach it
  fip_down_cnt #(.W(LEN_W)) u_pulse_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (len_i - LEN_W'(1)),
    .dec_i      (st_q == ST_PULSE),
    .cnt_o      (pcnt),
    .zero_o     (pcnt_zero)
  );

  generate
    if (ONSET_DLY > 0) begin : g_onset
      logic [DLY_W-1:0] dly_cnt;
      fip_down_cnt #(.W(DLY_W)) u_onset_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (accept),
        .load_val_i (DLY_W'(ONSET_DLY - 1)),
        .dec_i      (st_q == ST_ONSET),
        .cnt_o      (dly_cnt),
        .zero_o     (dly_zero)
      );

      // R3
      onset_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_ONSET) && !dly_zero |=> (st_q == ST_ONSET) && (dly_cnt == $past(dly_cnt) - DLY_W'(1)));
    end else begin : g_no_onset
      assign dly_zero = 1'b1;
    end
  endgenerate

  assign int_n_o = (st_q != ST_PULSE);
  assign busy_o  = (st_q != ST_IDLE);

  // R5
  pulse_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PULSE) && !pcnt_zero |=> (st_q == ST_PULSE) && (pcnt == $past(pcnt) - LEN_W'(1)));

  // R4
  pulse_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PULSE) && pcnt_zero |=> (st_q == ST_IDLE));
endmodule

// File: rtl/fip_frame_int.sv
module fip_frame_int
  import fip_pkg::*;
#(
  parameter int LEN_W     = 6,
  parameter int LEN_RST   = 32,
  parameter int ONSET_DLY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_stb_i,
  input  logic             mode_i,
  input  logic             len_we_i,
  input  logic [LEN_W-1:0] len_wdata_i,
  output logic             int_n_o,
  output logic             busy_o
);
  logic [LEN_W-1:0] len_q;

  fip_len_reg #(.LEN_W(LEN_W), .LEN_RST(LEN_RST)) u_len (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (len_we_i),
    .wdata_i (len_wdata_i),
    .len_o   (len_q)
  );

  fip_seq #(.LEN_W(LEN_W), .ONSET_DLY(ONSET_DLY)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_stb_i (frame_stb_i),
    .mode_i      (mode_i),
    .len_i       (len_q),
    .int_n_o     (int_n_o),
    .busy_o      (busy_o)
  );

  // R6
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_i && !busy_o && (len_q == '0) |=> !busy_o && int_n_o);

  // R2
  base_onset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_i && !busy_o && (len_q != '0) && (fip_mode_e'(mode_i) == MODE_BASE) |=> !int_n_o && busy_o);

  // R3
  late_onset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_i && !busy_o && (len_q != '0) && (fip_mode_e'(mode_i) == MODE_LATE)
      |=> busy_o && (int_n_o || (ONSET_DLY == 0)));
endmodule

// File: tb/fip_frame_int_bench.sv
`timescale 1ns/1ps
module fip_frame_int_bench;
  typedef struct {
    logic  int_n;
    logic  busy;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0;
  logic       mode = 1'b0;
  logic       len_we = 1'b0;
  logic [5:0] len_d = '0;
  logic       int_n;
  logic       busy;

  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  fip_frame_int u_fip_frame_int (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .frame_stb_i (stb),
    .mode_i      (mode),
    .len_we_i    (len_we),
    .len_wdata_i (len_d),
    .int_n_o     (int_n),
    .busy_o      (busy)
  );

  // monitor: one expected item per clock edge, sampled 5 ns after it
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (int_n !== e.int_n || busy !== e.busy) begin
          failures++;
          $display("FAIL %s: int_n=%b busy=%b expected int_n=%b busy=%b at %0t",
                   e.tag, int_n, busy, e.int_n, e.busy, $time);
        end
      end
    end
  end

  task automatic push(input logic i, input logic b, input string tag);
    exp_t e;
    e.int_n = i; e.busy = b; e.tag = tag;
    q.push_back(e);
  endtask

  // trace for a strobe accepted at the coming edge
  task automatic push_trace(input logic m, input int n, input string tag);
    if (m) begin
      push(1'b1, 1'b1, tag);
      push(1'b1, 1'b1, tag);
    end
    for (int i = 0; i < n; i++) push(1'b0, 1'b1, tag);
    push(1'b1, 1'b0, "R4");
  endtask

  // call at a negedge; returns at the next negedge with strobe low
  task automatic fire_now(input logic m, input int n, input string tag);
    stb = 1'b1;
    mode = m;
    push_trace(m, n, tag);
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic write_len(input logic [5:0] v);
    @(negedge clk);
    len_we = 1'b1;
    len_d = v;
    @(negedge clk);
    len_we = 1'b0;
  endtask

  initial begin
    #15;
    // R1 reset state
    checks++;
    if (int_n !== 1'b1 || busy !== 1'b0) begin
      failures++;
      $display("FAIL R1: int_n=%b busy=%b expected int_n=1 busy=0", int_n, busy);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset length 32, R2 baseline
    fire_now(1'b0, 32, "R1");
    drain();
    // R3 late onset
    @(negedge clk);
    fire_now(1'b1, 32, "R3");
    drain();

    // R7 new length, R2 min length
    write_len(6'd1);
    @(negedge clk);
    fire_now(1'b0, 1, "R2");
    drain();
    @(negedge clk);
    fire_now(1'b1, 1, "R3");
    drain();
    write_len(6'd63);
    @(negedge clk);
    fire_now(1'b0, 63, "R7");
    drain();

    // R5 strobes mid-pulse, at the ending edge, then accept right after
    write_len(6'd10);
    @(negedge clk);
    fire_now(1'b0, 10, "R5");          // accepted at k; now before k+1
    repeat (3) @(negedge clk);         // before k+4
    stb = 1'b1;
    repeat (3) @(negedge clk);         // strobe at k+4..k+6
    stb = 1'b0;
    repeat (3) @(negedge clk);         // before k+10 (pulse end edge)
    stb = 1'b1;                        // ignored: still busy
    @(negedge clk);                    // before k+11
    fire_now(1'b0, 10, "R5");          // accepted
    drain();

    // R5 strobe held across late-mode onset
    @(negedge clk);
    stb = 1'b1;
    mode = 1'b1;
    push_trace(1'b1, 10, "R5");
    repeat (3) @(negedge clk);
    stb = 1'b0;
    drain();

    // R6 zero length suppresses pulse in both modes
    write_len(6'd0);
    @(negedge clk);
    stb = 1'b1;
    mode = 1'b0;
    push(1'b1, 1'b0, "R6");
    @(negedge clk);
    mode = 1'b1;
    push(1'b1, 1'b0, "R6");
    @(negedge clk);
    stb = 1'b0;
    push(1'b1, 1'b0, "R6");
    drain();

    // R7 write during a pulse does not alter it
    write_len(6'd8);
    @(negedge clk);
    fire_now(1'b0, 8, "R7");
    len_we = 1'b1;
    len_d = 6'd5;
    @(negedge clk);
    len_we = 1'b0;
    drain();
    @(negedge clk);
    fire_now(1'b0, 5, "R7");
    drain();

    // R8 mode flip during a sequence
    write_len(6'd6);
    @(negedge clk);
    fire_now(1'b1, 6, "R8");
    mode = 1'b0;
    repeat (4) @(negedge clk);
    mode = 1'b1;
    drain();
    @(negedge clk);
    fire_now(1'b0, 6, "R8");
    mode = 1'b1;
    drain();

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule